// File: doc/BRIEF.md
# Cache-Aware Bus Command Selector for a DMA Master

This block picks the PCI bus command that a DMA master places on the bus at the start of each bus ownership. A read becomes a plain Memory Read, a Memory Read Line or a Memory Read Multiple. A write becomes a Memory Write or a Memory Write and Invalidate. The choice depends on four configuration enables, the cache line size, the programmed burst size, the current address, the number of words still to move and whether the read fetches an opcode. Alongside the command it gives the burst length for that ownership, trimmed so that no burst runs past a cache line boundary.

The bus interface pulses `own_req` when it wins the bus and reads `cmd_code` and `burst_words_out` on the next cycle. When an ownership ends early, the interface reports how the target ended it on `term_valid` and `term_kind`. After a retry of a Memory Write and Invalidate, the next write ownership reissues that command. After a disconnect, the normal qualification rules apply again. The line size and burst size are counted in 32-bit words.

Top module: `pcs_cmd_select`

## Requirements
- R1: While `rst` is high, and after it until the first request, `cmd_valid` is 0, `cmd_code` is 4'b0000 and `burst_words_out` is 0.
- R2: `cmd_valid` is 1 in exactly the cycle after a cycle with `own_req` high. In cycles that follow no request, `cmd_code` and `burst_words_out` keep their previous values.
- R3: Only the line sizes 2, 4, 8, 16, 32, 64 and 128 are legal. With cache mode on and an illegal line size, no read returns 4'b1110 or 4'b1100 and no write returns 4'b1111, unless R9 applies.
- R4: A line qualifies when all of these hold: the line size is legal, the line size is no larger than the burst size, the word address (`addr[9:2]`) modulo the line size is 0, and the remaining count is at least the burst size. With cache mode on, read-line enabled and a qualifying line, a read that is not an opcode fetch returns Memory Read Line (4'b1110). If R7 does not apply and any of these conditions fails, the read returns Memory Read (4'b0110).
- R5: With cache mode off, every read that is not an opcode fetch returns 4'b1110 when read-line is enabled and 4'b0110 when it is not.
- R6: An opcode fetch read always returns 4'b0110.
- R7: With cache mode on, read-multiple enabled, a qualifying line (R4) and at least two full lines remaining, a read that is not an opcode fetch returns Memory Read Multiple (4'b1100). This takes priority over Memory Read Line.
- R8: A write returns Memory Write and Invalidate (4'b1111) when cache mode and write-invalidate are enabled and the line qualifies (R4). Otherwise it returns Memory Write (4'b0111).
- R9: If the target retries (`term_kind` 2'd1) an ownership that issued 4'b1111, the next write returns 4'b1111 whenever cache mode and write-invalidate are enabled, whatever the count, alignment or line size.
- R10: After a disconnect (`term_kind` 2'd2) or a normal completion (2'd0), the next write is judged by R8 alone. It uses 4'b1111 only if the resume address is line aligned and the other R8 conditions hold.
- R11: `burst_words_out` is the smallest of three values: the burst size, the remaining count and, when cache mode is on with a legal line size, the words left to the next line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_req | input | 1 | Bus ownership won; a command is needed |
| is_write | input | 1 | 1 for a write ownership, 0 for a read |
| op_fetch | input | 1 | Read fetches an opcode |
| cache_mode | input | 1 | Cache mode enable |
| rd_line_en | input | 1 | Read-line enable |
| rd_mult_en | input | 1 | Read-multiple enable |
| wr_inv_en | input | 1 | Write-and-invalidate enable |
| line_words | input | 8 | Cache line size in words |
| burst_words | input | 8 | Programmed burst size in words |
| addr | input | 32 | Current byte address |
| remain_words | input | 16 | Words still to transfer |
| term_valid | input | 1 | Termination report strobe |
| term_kind | input | 2 | 0 completed, 1 retry, 2 disconnect |
| cmd_valid | output | 1 | Command and length are valid |
| cmd_code | output | 4 | PCI bus command |
| burst_words_out | output | 16 | Burst length for this ownership |

## Verification
A request sampled at one rising edge shows up in `cmd_valid`, `cmd_code` and `burst_words_out` after that same edge. The bench drives each request at a falling edge and compares the outputs at the next falling edge against its own model. A termination report changes only the retry memory. Its effect is therefore checked on the first write request that follows, one cycle after that request is sampled. Cycles with no request are compared too, to show that the outputs hold their values.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [3:0] CMD_MR  = 4'b0110;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MWI = 4'b1111;

  typedef enum logic [1:0] {
    TERM_DONE  = 2'd0,
    TERM_RETRY = 2'd1,
    TERM_DISC  = 2'd2
  } term_t;
endpackage

// File: rtl/pcs_line_geom.sv
module pcs_line_geom #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              cache_mode,
  input  logic [LINE_W-1:0] line_words,
  input  logic [LINE_W-1:0] burst_words,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  remain_words,
  output logic              line_legal,
  output logic              line_ok,
  output logic              two_lines,
  output logic [CNT_W-1:0]  blen
);
  localparam int MAX_LOG = 7;
  localparam int NPOW    = (LINE_W - 1 < MAX_LOG) ? LINE_W - 1 : MAX_LOG;

  logic [NPOW:1]     pow_hit;
  logic [LINE_W-1:0] word_lo;
  logic [LINE_W-1:0] offset;
  logic [LINE_W:0]   to_bound;
  logic              aligned;

  genvar k;
  generate
    for (k = 1; k <= NPOW; k++) begin : g_pow
      assign pow_hit[k] = (line_words == LINE_W'(1 << k));
    end
  endgenerate

  assign line_legal = |pow_hit;
  assign word_lo    = addr[LINE_W+1:2];
  assign offset     = word_lo & (line_words - LINE_W'(1));
  assign aligned    = (offset == '0);
  assign to_bound   = {1'b0, line_words} - {1'b0, offset};

  assign line_ok = line_legal && aligned
                && (line_words <= burst_words)
                && ({{(CNT_W-LINE_W){1'b0}}, burst_words} <= remain_words);

  assign two_lines = ({1'b0, remain_words}) >=
                     ({{(CNT_W-LINE_W){1'b0}}, line_words, 1'b0});

  always_comb begin
    blen = {{(CNT_W-LINE_W){1'b0}}, burst_words};
    if (cache_mode && line_legal &&
        ({{(CNT_W-LINE_W-1){1'b0}}, to_bound} < blen))
      blen = {{(CNT_W-LINE_W-1){1'b0}}, to_bound};
    if (remain_words < blen)
      blen = remain_words;
  end
endmodule

// File: rtl/pcs_read_pick.sv
module pcs_read_pick
  import pcs_pkg::*;
(
  input  logic       op_fetch,
  input  logic       cache_mode,
  input  logic       rd_line_en,
  input  logic       rd_mult_en,
  input  logic       line_ok,
  input  logic       two_lines,
  output logic [3:0] rd_cmd
);
  always_comb begin
    rd_cmd = CMD_MR;
    if (!op_fetch) begin
      if (cache_mode) begin
        if (rd_mult_en && line_ok && two_lines)
          rd_cmd = CMD_MRM;
        else if (rd_line_en && line_ok)
          rd_cmd = CMD_MRL;
      end else if (rd_line_en) begin
        rd_cmd = CMD_MRL;
      end
    end
  end
endmodule

// File: rtl/pcs_write_pick.sv
module pcs_write_pick
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       own_req,
  input  logic       is_write,
  input  logic       cache_mode,
  input  logic       wr_inv_en,
  input  logic       line_ok,
  input  logic       term_valid,
  input  logic [1:0] term_kind,
  output logic [3:0] wr_cmd
);
  logic last_inv;
  logic retry_pend;

  always_comb begin
    wr_cmd = CMD_MW;
    if (cache_mode && wr_inv_en && (retry_pend || line_ok))
      wr_cmd = CMD_MWI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_inv   <= 1'b0;
      retry_pend <= 1'b0;
    end else if (own_req && is_write) begin
      last_inv   <= (wr_cmd == CMD_MWI);
      retry_pend <= 1'b0;
    end else if (own_req) begin
      last_inv   <= 1'b0;
    end else if (term_valid) begin
      retry_pend <= (term_kind == TERM_RETRY) && last_inv;
    end
  end
endmodule

// File: rtl/pcs_cmd_select.sv
module pcs_cmd_select
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_req,
  input  logic              is_write,
  input  logic              op_fetch,
  input  logic              cache_mode,
  input  logic              rd_line_en,
  input  logic              rd_mult_en,
  input  logic              wr_inv_en,
  input  logic [LINE_W-1:0] line_words,
  input  logic [LINE_W-1:0] burst_words,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  remain_words,
  input  logic              term_valid,
  input  logic [1:0]        term_kind,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [CNT_W-1:0]  burst_words_out
);
  logic             line_legal;
  logic             line_ok;
  logic             two_lines;
  logic [CNT_W-1:0] blen;
  logic [3:0]       rd_cmd;
  logic [3:0]       wr_cmd;

  pcs_line_geom #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_geom (
    .cache_mode   (cache_mode),
    .line_words   (line_words),
    .burst_words  (burst_words),
    .addr         (addr),
    .remain_words (remain_words),
    .line_legal   (line_legal),
    .line_ok      (line_ok),
    .two_lines    (two_lines),
    .blen         (blen)
  );

  pcs_read_pick u_rd (
    .op_fetch   (op_fetch),
    .cache_mode (cache_mode),
    .rd_line_en (rd_line_en),
    .rd_mult_en (rd_mult_en),
    .line_ok    (line_ok),
    .two_lines  (two_lines),
    .rd_cmd     (rd_cmd)
  );

  pcs_write_pick u_wr (
    .clk        (clk),
    .rst        (rst),
    .own_req    (own_req),
    .is_write   (is_write),
    .cache_mode (cache_mode),
    .wr_inv_en  (wr_inv_en),
    .line_ok    (line_ok),
    .term_valid (term_valid),
    .term_kind  (term_kind),
    .wr_cmd     (wr_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid       <= 1'b0;
      cmd_code        <= 4'b0000;
      burst_words_out <= '0;
    end else begin
      cmd_valid <= own_req;
      if (own_req) begin
        cmd_code        <= is_write ? wr_cmd : rd_cmd;
        burst_words_out <= blen;
      end
    end
  end
endmodule

// File: rtl/pcs_cmd_select_chk.sv
module pcs_cmd_select_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              own_req,
  input logic              is_write,
  input logic              op_fetch,
  input logic              cache_mode,
  input logic              rd_line_en,
  input logic              rd_mult_en,
  input logic              wr_inv_en,
  input logic [LINE_W-1:0] line_words,
  input logic [LINE_W-1:0] burst_words,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  remain_words,
  input logic              cmd_valid,
  input logic [3:0]        cmd_code,
  input logic [CNT_W-1:0]  burst_words_out
);
  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    own_req |=> cmd_valid);
  p_valid_only_after_req_r2: assert property (@(posedge clk) disable iff (rst)
    !own_req |=> !cmd_valid);
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !own_req |=> ($stable(cmd_code) && $stable(burst_words_out)));
  p_opfetch_plain_r6: assert property (@(posedge clk) disable iff (rst)
    (own_req && !is_write && op_fetch) |=> (cmd_code == 4'b0110));
  p_write_family_r8: assert property (@(posedge clk) disable iff (rst)
    (own_req && is_write) |=> (cmd_code == 4'b0111 || cmd_code == 4'b1111));
  p_no_inv_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    (own_req && is_write && !wr_inv_en) |=> (cmd_code == 4'b0111));
  p_read_plain_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (own_req && !is_write && !rd_line_en && !rd_mult_en) |=> (cmd_code == 4'b0110));
  p_len_bounded_r11: assert property (@(posedge clk) disable iff (rst)
    own_req |=> (burst_words_out <= CNT_W'($past(burst_words))
              && burst_words_out <= $past(remain_words)));
endmodule

bind pcs_cmd_select pcs_cmd_select_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .own_req(own_req), .is_write(is_write),
  .op_fetch(op_fetch), .cache_mode(cache_mode), .rd_line_en(rd_line_en),
  .rd_mult_en(rd_mult_en), .wr_inv_en(wr_inv_en), .line_words(line_words),
  .burst_words(burst_words), .addr(addr), .remain_words(remain_words),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .burst_words_out(burst_words_out)
);

// File: tb/sim_pcs_cmd_select.sv
`timescale 1ns/1ps
module sim_pcs_cmd_select;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        own_req = 1'b0, is_write = 1'b0, op_fetch = 1'b0;
  logic        cache_mode = 1'b0, rd_line_en = 1'b0, rd_mult_en = 1'b0, wr_inv_en = 1'b0;
  logic [7:0]  line_words = '0, burst_words = '0;
  logic [31:0] addr = '0;
  logic [15:0] remain_words = '0;
  logic        term_valid = 1'b0;
  logic [1:0]  term_kind = '0;
  logic        cmd_valid;
  logic [3:0]  cmd_code;
  logic [15:0] burst_words_out;

  always #2.5 clk = ~clk;

  pcs_cmd_select u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  // reference model state
  bit          exp_valid = 0;
  logic [3:0]  exp_cmd = 4'b0000;
  int          exp_len = 0;
  string       exp_tag = "R1";
  bit          m_last_inv = 0, m_retry = 0;

  function automatic bit legal(int c);
    return (c == 2 || c == 4 || c == 8 || c == 16 || c == 32 || c == 64 || c == 128);
  endfunction

  task automatic check_outputs();
    checks++;
    if (cmd_valid !== exp_valid) begin
      failures++;
      $display("FAIL R2 %s valid actual=%0b expected=%0b", exp_tag, cmd_valid, exp_valid);
    end
    checks++;
    if (cmd_code !== exp_cmd) begin
      failures++;
      $display("FAIL %s cmd actual=%b expected=%b", exp_tag, cmd_code, exp_cmd);
    end
    checks++;
    if (int'(burst_words_out) !== exp_len) begin
      failures++;
      $display("FAIL R11 (%s) len actual=%0d expected=%0d", exp_tag, burst_words_out, exp_len);
    end
  endtask

  task automatic step(input bit rq, input bit wr, input bit of, input bit ce,
                      input bit rl, input bit rm, input bit we, input int c,
                      input int b, input int a, input int r, input bit tv,
                      input int tk);
    int  wa, off, lim;
    bit  qual, two;
    @(negedge clk);
    check_outputs();
    own_req = rq; is_write = wr; op_fetch = of; cache_mode = ce;
    rd_line_en = rl; rd_mult_en = rm; wr_inv_en = we;
    line_words = 8'(c); burst_words = 8'(b); addr = 32'(a);
    remain_words = 16'(r); term_valid = tv; term_kind = 2'(tk);
    exp_valid = rq;
    if (rq) begin
      wa   = (a >> 2) & 255;
      off  = legal(c) ? (wa % c) : 1;
      qual = legal(c) && off == 0 && c <= b && r >= b;
      two  = r >= 2 * c;
      lim  = b;
      if (ce && legal(c) && (c - off) < lim) lim = c - off;
      if (r < lim) lim = r;
      exp_len = lim;
      if (wr) begin
        exp_tag = m_retry ? "R9" : "R8";
        if (ce && !legal(c) && !m_retry) exp_tag = "R3";
        exp_cmd = (ce && we && (m_retry || qual)) ? 4'b1111 : 4'b0111;
        m_last_inv = (exp_cmd == 4'b1111);
        m_retry = 0;
      end else begin
        m_last_inv = 0;
        if (of) begin exp_cmd = 4'b0110; exp_tag = "R6"; end
        else if (!ce) begin exp_cmd = rl ? 4'b1110 : 4'b0110; exp_tag = "R5"; end
        else begin
          exp_tag = ce && !legal(c) ? "R3" : "R4";
          if (rm && qual && two) begin exp_cmd = 4'b1100; exp_tag = "R7"; end
          else if (rl && qual) exp_cmd = 4'b1110;
          else exp_cmd = 4'b0110;
        end
      end
    end else begin
      exp_tag = "R2";
      if (tv) m_retry = (tk == 1) && m_last_inv;
      if (tv && tk == 2) exp_tag = "R10";
    end
  endtask

  initial begin
    int cls_tab[10] = '{2, 4, 8, 16, 32, 64, 128, 0, 3, 6};
    int bur_tab[6]  = '{4, 8, 16, 32, 64, 128};
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk);
    checks++;
    if (cmd_valid !== 1'b0 || cmd_code !== 4'b0000 || burst_words_out !== 16'd0) begin
      failures++;
      $display("FAIL R1 reset actual=%0b/%b/%0d expected=0/0000/0", cmd_valid, cmd_code, burst_words_out);
    end
    rst = 1'b0;
    // R1 again after release, R2 hold
    step(0,0,0,0,0,0,0, 0,0,0,0, 0,0);
    // R5: cache off, read line enabled, unaligned address
    step(1,0,0,0,1,0,0, 16,16,32'h44,100, 0,0);
    step(1,0,1,0,1,0,0, 16,16,32'h40,100, 0,0);   // R6
    // R4: cache on, qualifying line
    step(1,0,0,1,1,0,0, 8,16,32'h100,64, 0,0);
    step(1,0,0,1,1,0,0, 8,16,32'h104,64, 0,0);    // R4 misaligned
    step(1,0,0,1,1,0,0, 8,16,32'h100,15, 0,0);    // R4 count short
    step(1,0,0,1,1,0,0, 32,16,32'h0,64, 0,0);     // R4 line > burst
    step(1,0,0,1,1,0,0, 12,16,32'h0,64, 0,0);     // R3 illegal size
    // R7: multiple priority vs one line only
    step(1,0,0,1,1,1,0, 8,8,32'h200,16, 0,0);
    step(1,0,0,1,1,1,0, 8,8,32'h200,15, 0,0);
    step(1,0,1,1,1,1,0, 8,8,32'h200,64, 0,0);     // R6 with cache on
    // R8 write invalidate and fallback
    step(1,1,0,1,0,0,1, 8,8,32'h80,64, 0,0);
    step(1,1,0,1,0,0,1, 8,8,32'h84,64, 0,0);
    // R9: invalidate write, retry, resume misaligned short
    step(1,1,0,1,0,0,1, 8,8,32'h80,64, 0,0);
    step(0,0,0,1,0,0,1, 8,8,0,0, 1,1);
    step(0,0,0,1,0,0,1, 8,8,0,0, 0,0);
    step(1,1,0,1,0,0,1, 3,8,32'h84,2, 0,0);
    // R10: invalidate write, disconnect, misaligned resume
    step(1,1,0,1,0,0,1, 8,8,32'h80,64, 0,0);
    step(0,0,0,1,0,0,1, 8,8,0,0, 1,2);
    step(1,1,0,1,0,0,1, 8,8,32'h88,64, 0,0);
    step(1,1,0,1,0,0,1, 8,8,32'h8c,64, 0,0);
    step(0,0,0,1,0,0,1, 8,8,0,0, 1,2);
    step(1,1,0,1,0,0,1, 8,8,32'ha0,64, 0,0);      // R10 aligned resume
    // R9 negative: retry after plain write keeps plain
    step(1,1,0,1,0,0,1, 8,8,32'h84,64, 0,0);
    step(0,0,0,1,0,0,1, 8,8,0,0, 1,1);
    step(1,1,0,1,0,0,1, 8,8,32'h84,64, 0,0);
    // R11 boundary trim
    step(1,0,0,1,0,0,0, 16,32,32'h38,100, 0,0);
    step(1,0,0,0,0,0,0, 16,32,32'h38,100, 0,0);
    step(0,0,0,0,0,0,0, 0,0,0,0, 0,0);
    for (int i = 0; i < 3000; i++) begin
      int c, b, a, r;
      c = cls_tab[$urandom_range(0, 9)];
      b = bur_tab[$urandom_range(0, 5)];
      a = $urandom_range(0, 32'h3fff) & ~3;
      if ($urandom_range(0, 2) != 0 && legal(c)) a = a & ~((c * 4) - 1);
      r = $urandom_range(0, 400);
      step($urandom_range(0, 2) != 0, $urandom_range(0, 1), $urandom_range(0, 4) == 0,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, c, b, a, r,
           $urandom_range(0, 1), $urandom_range(0, 2));
    end
    step(0,0,0,0,0,0,0, 0,0,0,0, 0,0);
    @(negedge clk);
    check_outputs();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule